// File: doc/BRIEF.md
# Key-Armed Watchdog Timer

This block is a watchdog timer for a small microcontroller. It stays idle until software writes an ordered pair of key bytes to its key register. After that it counts oscillator-derived clocks. Writing the same pair again restarts the count. If software does not do so before the selected interval runs out, the block drives an active-high reset pulse of fixed length, which resets the whole system.

Once armed, the block stays armed until the system reset. No register write can turn it off. A 3-bit field in a separate programming register picks one of eight timeouts. The timeout grows by powers of two from a base exponent, and each count step takes six watchdog clocks. The watchdog clock is either the oscillator itself or the oscillator halved, selected by a mode input.

During idle the count runs normally. During power-down the count and all dividers freeze and then resume from where they stopped. A reset that ends power-down clears and disarms the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After the system reset (`sys_rst` high, synchronous) the watchdog is disarmed, its counters are zero and `wd_rst_o` is low; a disarmed watchdog never pulses.
- R2: A write (`wr_en` high) with `wr_sel`=0 (key register) of 0x1E followed by a key write of 0xE1 arms the watchdog, and counting starts from zero at the edge that captures 0xE1.
- R3: While armed, the same 0x1E then 0xE1 pair clears the count and the divide-by-PRE_DIV prescaler, so servicing at intervals shorter than the timeout never produces a pulse.
- R4: A key write of any value other than 0xE1 right after 0x1E cancels the pair, and every 0x1E write starts a new pair (0x1E, 0x1E, 0xE1 arms).
- R5: Once armed, no write disarms or clears the watchdog; for example, key writes of 0x00 or 0xFF leave the expiry time unchanged.
- R6: With `x2_mode`=1, `wd_rst_o` rises exactly PRE_DIV×(2^(BASE_EXP+WTO)−1) clock cycles after the edge that captured the last 0xE1. WTO is `wr_data[2:0]` of the last write with `wr_sel`=1 (programming register), and it resets to 0.
- R7: With `x2_mode`=0, the watchdog clock is the oscillator divided by two, so the interval in R6 doubles.
- R8: Each expiry holds `wd_rst_o` high for exactly PULSE_LEN (96) cycles. The count is held at zero during the pulse, and the next expiry comes a full timeout after the pulse ends.
- R9: `idle` has no effect on counting.
- R10: Each clock cycle with `pwr_down` high freezes the count and the dividers, which delays the expiry by exactly that many cycles.
- R11: A system reset while armed disarms the block and clears the count, so no pulse follows until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| x2_mode | input | 1 | 1: watchdog clock = oscillator; 0: oscillator / 2 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: key register, 1: programming register |
| wr_data | input | 8 | Write data |
| idle | input | 1 | Idle mode indication (no effect on counting) |
| pwr_down | input | 1 | Power-down indication; freezes counting |
| wd_rst_o | output | 1 | Active-high reset pulse on expiry |

## Verification
Each key or programming write takes effect at the rising edge where `wr_en` is high. The rising edge of `wd_rst_o` is due exactly R6's interval after that edge, doubled in half-rate mode and lengthened by one cycle for every power-down cycle. The bench keeps a free-running edge counter and drives every input on falling edges. It samples `wd_rst_o` on falling edges, so a measured interval is the edge count between the capturing edge and the first edge that shows the output high. It counts the pulse width the same way, and it measures the following expiry from the falling edge of the pulse.

// File: rtl/wdkey_pkg.sv
package wdkey_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'h1E;
   localparam logic [7:0] KEY_SECOND = 8'hE1;
   localparam logic       SEL_KEY    = 1'b0;
   localparam logic       SEL_PROG   = 1'b1;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdkey_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   output logic       armed_o,
   output logic       kick_o
);
   logic first_q;
   logic armed_q;
   logic key_wr;

   assign key_wr  = wr_en && (wr_sel == SEL_KEY);
   assign kick_o  = key_wr && first_q && (wr_data == KEY_SECOND);
   assign armed_o = armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (key_wr) first_q <= (wr_data == KEY_FIRST);
         if (kick_o) armed_q <= 1'b1;
      end
   end

   // R5
   armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      armed_q |=> armed_q);

   // R2
   arm_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(armed_q) |-> $past(wr_en && wr_sel == SEL_KEY && wr_data == KEY_SECOND));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int PRE_DIV = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic x2_mode,
   input  logic hold,
   input  logic clear,
   output logic tick_o
);
   localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic half_q;
   logic wclk_en;

   always_ff @(posedge clk) begin
      if (rst || clear) half_q <= 1'b0;
      else if (!hold)   half_q <= ~half_q;
   end

   assign wclk_en = (x2_mode | half_q) & ~hold & ~clear;

   generate
      if (PRE_DIV == 1) begin : g_nodiv
         assign tick_o = wclk_en;
      end else begin : g_div
         localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (rst || clear) pre_q <= '0;
            else if (wclk_en) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
         assign tick_o = wclk_en && (pre_q == LAST);

         // R10
         pre_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            hold && !clear |=> $stable(pre_q));
      end
   endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int BASE_EXP = 14,
   parameter int WTO_W    = 3,
   parameter int CNT_W    = BASE_EXP + (1 << WTO_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             tick,
   input  logic             hold,
   input  logic [WTO_W-1:0] wto,
   output logic             expire_o
);
   localparam logic [WTO_W-1:0] WMAX = WTO_W'((1 << WTO_W) - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic [WTO_W-1:0] sh;

   assign sh       = WMAX - wto;
   assign limit    = {CNT_W{1'b1}} >> sh;
   assign expire_o = tick && (cnt_q >= limit - ONE);

   always_ff @(posedge clk) begin
      if (rst || clear)  cnt_q <= '0;
      else if (expire_o) cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + ONE;
   end

   // R10
   count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      hold && !clear |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int PULSE_LEN = 96
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic busy_o
);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam int HW = $clog2(PULSE_LEN + 2);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)              left_q <= '0;
      else if (fire)        left_q <= PW'(PULSE_LEN);
      else if (left_q != 0) left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != 0);

   logic [HW-1:0] hi_len;
   always_ff @(posedge clk) begin
      if (rst) hi_len <= '0;
      else     hi_len <= busy_o ? hi_len + 1'b1 : '0;
   end

   // R8
   pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> hi_len == HW'(PULSE_LEN));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdkey_pkg::*;
#(
   parameter int BASE_EXP  = 14,
   parameter int WTO_W     = 3,
   parameter int PRE_DIV   = 6,
   parameter int PULSE_LEN = 96
) (
   input  logic       clk,
   input  logic       sys_rst,
   input  logic       x2_mode,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       idle,
   input  logic       pwr_down,
   output logic       wd_rst_o
);
   localparam int CNT_W = BASE_EXP + (1 << WTO_W) - 1;

   initial begin
      base_exp_chk:  assert (BASE_EXP >= 1);
      wto_width_chk: assert (WTO_W >= 1 && WTO_W <= 4);
      pre_div_chk:   assert (PRE_DIV >= 1);
      pulse_len_chk: assert (PULSE_LEN >= 1);
   end

   logic             armed;
   logic             kick;
   logic             tick;
   logic             expire;
   logic             busy;
   logic             clear_all;
   logic [WTO_W-1:0] wto_q;
   logic             idle_unused;

   assign idle_unused = idle;
   assign clear_all   = kick | ~armed | busy;

   always_ff @(posedge clk) begin
      if (sys_rst) wto_q <= '0;
      else if (wr_en && wr_sel == SEL_PROG) wto_q <= wr_data[WTO_W-1:0];
   end

   wdt_keyseq u_key (
      .clk(clk), .rst(sys_rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .armed_o(armed), .kick_o(kick)
   );

   wdt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst(sys_rst), .x2_mode(x2_mode), .hold(pwr_down),
      .clear(clear_all), .tick_o(tick)
   );

   wdt_counter #(.BASE_EXP(BASE_EXP), .WTO_W(WTO_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(sys_rst), .clear(clear_all), .tick(tick),
      .hold(pwr_down), .wto(wto_q), .expire_o(expire)
   );

   wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst(sys_rst), .fire(expire), .busy_o(busy)
   );

   assign wd_rst_o = busy;

   // R8
   expire_pulse_chk: assert property (@(posedge clk) disable iff (sys_rst)
      expire |=> wd_rst_o);

   // R8
   no_count_in_pulse_chk: assert property (@(posedge clk) disable iff (sys_rst)
      wd_rst_o |-> !expire);

   // R1
   disarmed_quiet_chk: assert property (@(posedge clk) disable iff (sys_rst)
      !armed |=> !wd_rst_o);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam int BEXP = 4;
   localparam int PLEN = 96;

   logic       clk = 1'b0;
   logic       sys_rst = 1'b1;
   logic       x2_mode = 1'b1;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       idle = 1'b0;
   logic       pwr_down = 1'b0;
   logic       wd_rst_o;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   int last_wr = 0;

   keyed_watchdog #(.BASE_EXP(BEXP), .PULSE_LEN(PLEN)) uut (
      .clk(clk), .sys_rst(sys_rst), .x2_mode(x2_mode), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .idle(idle), .pwr_down(pwr_down),
      .wd_rst_o(wd_rst_o)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int timeout(input int wto, input bit x2);
      return (x2 ? 1 : 2) * 6 * ((1 << (BEXP + wto)) - 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      sys_rst = 1'b1;
      repeat (3) @(negedge clk);
      sys_rst = 1'b0;
   endtask

   task automatic wr(input bit sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      last_wr = cyc;
   endtask

   task automatic arm();
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'hE1);
   endtask

   task automatic quiet(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wd_rst_o) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   task automatic to_expiry(input int start, input int lim, input bit rnd,
                            output int elapsed, output int pdcnt);
      pdcnt = 0; elapsed = -1;
      for (int i = 0; i < lim; i++) begin
         if (rnd) begin
            idle = 1'($urandom % 2);
            pwr_down = ($urandom % 4 == 0);
            pdcnt += int'(pwr_down);
         end
         @(negedge clk);
         if (wd_rst_o) begin
            elapsed = cyc - start;
            break;
         end
      end
      pwr_down = 1'b0; idle = 1'b0;
   endtask

   task automatic pulse_width(output int w);
      w = 0;
      while (wd_rst_o && w < 1000) begin
         w++;
         @(negedge clk);
      end
   endtask

   initial begin
      int el, pd, w, t, fall, start;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      sys_rst = 1'b0;

      // R1: reset state and no pulse while disarmed
      check(wd_rst_o == 1'b0, "R1", wd_rst_o, 0);
      quiet(300, "R1");

      // R4: broken pair does not arm
      wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
      quiet(300, "R4");
      // R4: repeated first key restarts pair and arms
      wr(1'b0, 8'h1E); wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
      t = timeout(0, 1'b1);
      to_expiry(last_wr, 5000, 1'b0, el, pd);
      check(el == t, "R4/R6 wto0", el, t);
      // R8: width and next expiry
      pulse_width(w);
      check(w == PLEN, "R8 width", w, PLEN);
      fall = cyc;
      to_expiry(fall, 5000, 1'b0, el, pd);
      check(el == t, "R8 re-expiry", el, t);
      pulse_width(w);
      check(w == PLEN, "R8 width2", w, PLEN);

      // R3: servicing prevents expiry, then exact timeout from last service
      do_reset();
      wr(1'b1, 8'h02);
      arm();
      t = timeout(2, 1'b1);
      for (int k = 0; k < 8; k++) begin
         quiet(t - 60, "R3 serviced");
         arm();
      end
      to_expiry(last_wr, 5000, 1'b0, el, pd);
      check(el == t, "R3 after service", el, t);
      pulse_width(w);

      // R5: writes of 0x00/0xFF do not disarm or clear
      do_reset();
      wr(1'b1, 8'h01);
      arm();
      start = last_wr;
      wr(1'b0, 8'h00); wr(1'b0, 8'hFF); wr(1'b0, 8'h00);
      t = timeout(1, 1'b1);
      to_expiry(start, 5000, 1'b0, el, pd);
      check(el == t, "R5 armed after 0x00", el, t);
      pulse_width(w);

      // R7: half-rate mode
      do_reset();
      x2_mode = 1'b0;
      arm();
      t = timeout(0, 1'b0);
      to_expiry(last_wr, 5000, 1'b0, el, pd);
      check(el == t, "R7 x1 wto0", el, t);
      pulse_width(w);
      check(w == PLEN, "R8 width x1", w, PLEN);
      x2_mode = 1'b1;

      // R10: power-down freeze of 50 cycles
      do_reset();
      arm();
      start = last_wr;
      repeat (30) @(negedge clk);
      pwr_down = 1'b1;
      repeat (50) @(negedge clk);
      pwr_down = 1'b0;
      t = timeout(0, 1'b1) + 50;
      to_expiry(start, 5000, 1'b0, el, pd);
      check(el == t, "R10 pd hold", el, t);
      pulse_width(w);

      // R9: idle held high
      do_reset();
      wr(1'b1, 8'h01);
      idle = 1'b1;
      arm();
      start = last_wr;
      t = timeout(1, 1'b1);
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (wd_rst_o) begin el = cyc - start; break; end
      end
      idle = 1'b0;
      check(el == t, "R9 idle", el, t);
      pulse_width(w);

      // R11: reset while armed disarms
      do_reset();
      arm();
      repeat (50) @(negedge clk);
      do_reset();
      check(wd_rst_o == 1'b0, "R11 out", wd_rst_o, 0);
      quiet(400, "R11 disarmed");
      arm();
      t = timeout(0, 1'b1);
      to_expiry(last_wr, 5000, 1'b0, el, pd);
      check(el == t, "R11 rearm", el, t);
      pulse_width(w);

      // R6/R7/R9/R10: random mode, WTO, idle and power-down bursts
      for (int it = 0; it < 12; it++) begin
         int wto;
         bit x2;
         wto = int'($urandom % 4);
         x2 = 1'($urandom % 2);
         do_reset();
         x2_mode = x2;
         wr(1'b1, 8'(wto) | 8'hF8);
         arm();
         t = timeout(wto, x2);
         to_expiry(last_wr, 20000, 1'b1, el, pd);
         check(el == t + pd, "R6 random", el, t + pd);
         pulse_width(w);
         check(w == PLEN, "R8 random width", w, PLEN);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule